// File: doc/BRIEF.md
# Command Effects Log Generator

This block builds a command effects log in hardware and serves it to a mailbox front end. Coming out of reset, it walks every 16-bit opcode in ascending order. For each opcode in its built-in support table it appends one 32-bit entry to a small register file. The entry holds the opcode and that command's effect mask.

When the walk has covered the whole opcode space, the block raises `ready` and starts taking queries. A size query returns the length of the log in bytes. A get-log query names a 128-bit log identifier, a byte offset and a byte length. The block checks the request against the payload buffer size and against the identifier on `log_id`. It then either streams the requested bytes one per cycle and closes with a success response, or answers at once with an error code.

Queries use a valid/ready handshake. Responses are one-cycle pulses, with no back-pressure on the output side.

Top module: `cmd_effects_log`

## Requirements
- R1: After reset `ready` is low. It stays low while all 65536 opcodes (set 0..255, command 0..255 within a set) are visited one per cycle, then rises and stays high.
- R2: Entries are stored in ascending opcode order, where opcode = set*256 + command. The support table holds 13 opcodes: 0x0100..0x0103, 0x0200, 0x0300, 0x0301, 0x0400, 0x0401, 0x4000, 0x4100, 0x4102 and 0x4103.
- R3: Effect mask bits: bit 1 is an immediate configuration change, bit 2 an immediate data change, bit 3 an immediate policy change, bit 4 an immediate log change. The masks are 0x0010 for 0x0101, 0x0002 for 0x0103, 0x0008 for 0x0301, 0x0006 for 0x4103, and zero for every other supported opcode.
- R4: A size query (`q_kind`=0) answers with `rsp_code` 0x00 and `rsp_value` equal to 4 times the entry count, which is 52 for the built-in table.
- R5: A get-log query (`q_kind`=1) whose offset plus length exceeds PAYLOAD_BYTES (64) answers with `rsp_code` 0x02 and `rsp_value` 0, and streams no data bytes.
- R6: The offset-plus-length sum is taken one bit wider than the 32-bit fields, so a sum that wraps past 2^32 is still rejected with 0x02.
- R7: A get-log query that passes the bounds check but carries a `q_id` different from `log_id` answers with `rsp_code` 0x03 and no data. When both checks fail, the answer is 0x02.
- R8: A successful get-log query streams exactly `length` bytes on `dat_byte`, one per cycle, starting at byte `offset`. It then gives one response pulse with code 0x00 and `rsp_value` equal to the length. Bytes past the end of the log but inside the buffer read as zero.
- R9: Within each 4-byte entry the byte order is opcode low, opcode high, effect low, effect high.
- R10: `q_ready` is low while `ready` is low and while a query is being served, so a query held during the scan is accepted only after `ready` rises.
- R11: A get-log query with length 0 that passes both checks answers with code 0x00, value 0 and no data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_id | input | 128 | Identifier of this log, held constant |
| q_valid | input | 1 | Query request valid |
| q_kind | input | 1 | 0 = size query, 1 = get-log query |
| q_id | input | 128 | Log identifier named by a get-log query |
| q_offset | input | 32 | Byte offset of a get-log query |
| q_length | input | 32 | Byte length of a get-log query |
| q_ready | output | 1 | Query accepted on a clock edge when high together with q_valid |
| ready | output | 1 | Log construction finished |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_code | output | 8 | Return code: 0x00 success, 0x02 invalid input, 0x03 unsupported |
| rsp_value | output | 32 | Log size for a size query, response length for a get-log query |
| dat_valid | output | 1 | A log byte is presented this cycle |
| dat_byte | output | 8 | Log byte |

## Verification
The scan and query service overlap at the end of initialisation. A size query can already be waiting when the last opcode is visited. The bench raises a size query straight out of reset and holds it through the full 65536-cycle walk. It checks that `q_ready` and `rsp_valid` stay low on every cycle before `ready` rises. It then checks that the query is answered with the complete 52-byte size rather than a partial count. A second overlap is a new query that arrives while a stream is in progress. The bench judges it by watching that `q_ready` stays low until the response pulse.

// File: rtl/elog_pkg.sv
package elog_pkg;

  localparam int SET_W   = 8;
  localparam int CMD_W   = 8;
  localparam int OPC_W   = SET_W + CMD_W;
  localparam int EFF_W   = 16;
  localparam int ID_W    = 128;
  localparam int FIELD_W = 32;
  localparam int RC_W    = 8;
  localparam int BYTE_W  = 8;

  // effect mask bits
  localparam logic [EFF_W-1:0] EFF_CFG    = EFF_W'(16'h0002);
  localparam logic [EFF_W-1:0] EFF_DATA   = EFF_W'(16'h0004);
  localparam logic [EFF_W-1:0] EFF_POLICY = EFF_W'(16'h0008);
  localparam logic [EFF_W-1:0] EFF_LOG    = EFF_W'(16'h0010);

  // return codes
  localparam logic [RC_W-1:0] RC_OK         = RC_W'(8'h00);
  localparam logic [RC_W-1:0] RC_BAD_INPUT  = RC_W'(8'h02);
  localparam logic [RC_W-1:0] RC_NO_SUPPORT = RC_W'(8'h03);

  typedef enum logic [1:0] {
    SV_IDLE   = 2'd0,
    SV_STREAM = 2'd1,
    SV_RESP   = 2'd2
  } srv_state_e;

  typedef struct packed {
    logic [EFF_W-1:0] eff;
    logic [OPC_W-1:0] opc;
  } entry_t;

  typedef struct packed {
    logic             hit;
    logic [EFF_W-1:0] eff;
  } lookup_t;

  // support table: which opcodes exist and what they may change
  function automatic lookup_t opc_lookup(logic [OPC_W-1:0] opc);
    lookup_t r;
    r.hit = 1'b1;
    r.eff = '0;
    case (opc)
      OPC_W'(16'h0101): r.eff = EFF_LOG;
      OPC_W'(16'h0103): r.eff = EFF_CFG;
      OPC_W'(16'h0301): r.eff = EFF_POLICY;
      OPC_W'(16'h4103): r.eff = EFF_CFG | EFF_DATA;
      OPC_W'(16'h0100), OPC_W'(16'h0102), OPC_W'(16'h0200),
      OPC_W'(16'h0300), OPC_W'(16'h0400), OPC_W'(16'h0401),
      OPC_W'(16'h4000), OPC_W'(16'h4100), OPC_W'(16'h4102): r.eff = '0;
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction

  // little-endian lane selection within one entry
  function automatic logic [BYTE_W-1:0] entry_lane(entry_t e, logic [1:0] lane);
    logic [31:0] w;
    w = {e.eff, e.opc};
    return w[lane*BYTE_W +: BYTE_W];
  endfunction

  // bounds test in a sum one bit wider than the fields
  function automatic logic range_exceeds(logic [FIELD_W-1:0] off,
                                         logic [FIELD_W-1:0] len,
                                         logic [FIELD_W:0]   limit);
    logic [FIELD_W:0] sum;
    sum = {1'b0, off} + {1'b0, len};
    return sum > limit;
  endfunction

  function automatic logic [FIELD_W-1:0] log_size_bytes(logic [FIELD_W-1:0] n);
    return n << 2;
  endfunction

endpackage

// File: rtl/opcode_support.sv
module opcode_support
  import elog_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output logic             hit,
  output logic [EFF_W-1:0] eff
);
  lookup_t lk;
  assign lk  = opc_lookup(opc);
  assign hit = lk.hit;
  assign eff = lk.eff;
endmodule

// File: rtl/elog_scanner.sv
module elog_scanner
  import elog_pkg::*;
#(
  parameter  int MAX_ENTRIES = 16,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int IDX_W = $clog2(MAX_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             done,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output entry_t           wr_entry,
  output logic [CNT_W-1:0] count
);
  logic [OPC_W-1:0] scan_opc;
  logic [OPC_W-1:0] last_opc;
  logic             hit;
  logic [EFF_W-1:0] eff;
  logic             scan_last;

  opcode_support u_support (
    .opc (scan_opc),
    .hit (hit),
    .eff (eff)
  );

  assign scan_last    = (scan_opc == '1);
  assign wr_en        = !done && hit && (count < CNT_W'(MAX_ENTRIES));
  assign wr_idx       = IDX_W'(count);
  assign wr_entry.opc = scan_opc;
  assign wr_entry.eff = eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_opc <= '0;
      last_opc <= '0;
      count    <= '0;
      done     <= 1'b0;
    end else if (!done) begin
      if (wr_en) begin
        count    <= count + 1'b1;
        last_opc <= scan_opc;
      end
      if (scan_last) done <= 1'b1;
      else           scan_opc <= scan_opc + 1'b1;
    end
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) 32'(count) <= MAX_ENTRIES); // R2
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && count != '0) |-> (scan_opc > last_opc)); // R2
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) done |=> $stable(count)); // R4

endmodule

// File: rtl/elog_ram.sv
module elog_ram
  import elog_pkg::*;
#(
  parameter  int MAX_ENTRIES   = 16,
  parameter  int PAYLOAD_BYTES = 64,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int IDX_W = $clog2(MAX_ENTRIES),
  localparam int PTR_W = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  entry_t            wr_entry,
  input  logic [CNT_W-1:0]  count,
  input  logic [PTR_W-1:0]  byte_addr,
  output logic [BYTE_W-1:0] rd_byte
);
  entry_t mem [MAX_ENTRIES];

  logic [PTR_W-3:0] ent_sel;
  logic [1:0]       lane_sel;
  logic             in_log;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_entry;
  end

  assign ent_sel  = byte_addr[PTR_W-1:2];
  assign lane_sel = byte_addr[1:0];
  assign in_log   = (32'(ent_sel) < 32'(count));
  assign rd_byte  = in_log ? entry_lane(mem[IDX_W'(ent_sel)], lane_sel) : '0;

endmodule

// File: rtl/elog_server.sv
module elog_server
  import elog_pkg::*;
#(
  parameter  int MAX_ENTRIES   = 16,
  parameter  int PAYLOAD_BYTES = 64,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int PTR_W = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_done,
  input  logic [CNT_W-1:0]   count,
  input  logic [ID_W-1:0]    log_id,
  input  logic               q_valid,
  input  logic               q_kind,
  input  logic [ID_W-1:0]    q_id,
  input  logic [FIELD_W-1:0] q_offset,
  input  logic [FIELD_W-1:0] q_length,
  output logic               q_ready,
  output logic               rsp_valid,
  output logic [RC_W-1:0]    rsp_code,
  output logic [FIELD_W-1:0] rsp_value,
  output logic               dat_valid,
  output logic [PTR_W-1:0]   byte_addr,
  input  logic [BYTE_W-1:0]  rd_byte,
  output logic [BYTE_W-1:0]  dat_byte
);
  srv_state_e         st;
  logic [PTR_W-1:0]   ptr;
  logic [FIELD_W-1:0] rem;
  logic [FIELD_W-1:0] len_q;
  logic [RC_W-1:0]    code_q;
  logic [FIELD_W-1:0] value_q;

  // named events
  logic acc;
  logic acc_size;
  logic acc_get;
  logic bound_bad;
  logic id_bad;
  logic stream_last;

  assign q_ready     = init_done && (st == SV_IDLE);
  assign acc         = q_valid && q_ready;
  assign acc_size    = acc && !q_kind;
  assign acc_get     = acc && q_kind;
  assign bound_bad   = range_exceeds(q_offset, q_length, (FIELD_W+1)'(PAYLOAD_BYTES));
  assign id_bad      = (q_id != log_id);
  assign stream_last = (rem == FIELD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SV_IDLE;
      ptr     <= '0;
      rem     <= '0;
      len_q   <= '0;
      code_q  <= RC_OK;
      value_q <= '0;
    end else begin
      case (st)
        SV_IDLE: begin
          if (acc_size) begin
            code_q  <= RC_OK;
            value_q <= log_size_bytes(FIELD_W'(count));
            st      <= SV_RESP;
          end else if (acc_get) begin
            if (bound_bad) begin
              code_q  <= RC_BAD_INPUT;
              value_q <= '0;
              st      <= SV_RESP;
            end else if (id_bad) begin
              code_q  <= RC_NO_SUPPORT;
              value_q <= '0;
              st      <= SV_RESP;
            end else if (q_length == '0) begin
              code_q  <= RC_OK;
              value_q <= '0;
              st      <= SV_RESP;
            end else begin
              ptr   <= PTR_W'(q_offset);
              rem   <= q_length;
              len_q <= q_length;
              st    <= SV_STREAM;
            end
          end
        end
        SV_STREAM: begin
          ptr <= ptr + 1'b1;
          rem <= rem - 1'b1;
          if (stream_last) begin
            code_q  <= RC_OK;
            value_q <= len_q;
            st      <= SV_RESP;
          end
        end
        SV_RESP: st <= SV_IDLE;
        default: st <= SV_IDLE;
      endcase
    end
  end

  assign dat_valid = (st == SV_STREAM);
  assign byte_addr = ptr;
  assign dat_byte  = rd_byte;
  assign rsp_valid = (st == SV_RESP);
  assign rsp_code  = code_q;
  assign rsp_value = value_q;

  AST_STALL_WHILE_INIT: assert property (@(posedge clk) disable iff (!rst_n) !init_done |-> !q_ready); // R10
  AST_BOUND_BEFORE_ID: assert property (@(posedge clk) disable iff (!rst_n) (acc_get && bound_bad) |=> (rsp_valid && rsp_code == RC_BAD_INPUT)); // R7
  AST_ID_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (acc_get && !bound_bad && id_bad) |=> (rsp_valid && rsp_code == RC_NO_SUPPORT)); // R7
  AST_DATA_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dat_valid && rsp_valid)); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R8
  AST_STREAM_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n) dat_valid |-> (32'(byte_addr) < PAYLOAD_BYTES)); // R5

endmodule

// File: rtl/cmd_effects_log.sv
module cmd_effects_log
  import elog_pkg::*;
#(
  parameter int MAX_ENTRIES   = 16,
  parameter int PAYLOAD_BYTES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    log_id,
  input  logic               q_valid,
  input  logic               q_kind,
  input  logic [ID_W-1:0]    q_id,
  input  logic [FIELD_W-1:0] q_offset,
  input  logic [FIELD_W-1:0] q_length,
  output logic               q_ready,
  output logic               ready,
  output logic               rsp_valid,
  output logic [RC_W-1:0]    rsp_code,
  output logic [FIELD_W-1:0] rsp_value,
  output logic               dat_valid,
  output logic [BYTE_W-1:0]  dat_byte
);
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1);
  localparam int IDX_W = $clog2(MAX_ENTRIES);
  localparam int PTR_W = $clog2(PAYLOAD_BYTES + 1);

  logic              init_done;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  entry_t            wr_entry;
  logic [CNT_W-1:0]  count;
  logic [PTR_W-1:0]  byte_addr;
  logic [BYTE_W-1:0] rd_byte;

  elog_scanner #(.MAX_ENTRIES(MAX_ENTRIES)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (init_done),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_entry (wr_entry),
    .count    (count)
  );

  elog_ram #(.MAX_ENTRIES(MAX_ENTRIES), .PAYLOAD_BYTES(PAYLOAD_BYTES)) u_ram (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_entry  (wr_entry),
    .count     (count),
    .byte_addr (byte_addr),
    .rd_byte   (rd_byte)
  );

  elog_server #(.MAX_ENTRIES(MAX_ENTRIES), .PAYLOAD_BYTES(PAYLOAD_BYTES)) u_srv (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .count     (count),
    .log_id    (log_id),
    .q_valid   (q_valid),
    .q_kind    (q_kind),
    .q_id      (q_id),
    .q_offset  (q_offset),
    .q_length  (q_length),
    .q_ready   (q_ready),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsp_value (rsp_value),
    .dat_valid (dat_valid),
    .byte_addr (byte_addr),
    .rd_byte   (rd_byte),
    .dat_byte  (dat_byte)
  );

  assign ready = init_done;

endmodule

// File: tb/cmd_effects_log_tb.sv
`timescale 1ns/1ps
module cmd_effects_log_tb_top;

  localparam int BUF = 64;
  localparam logic [127:0] LOGID = 128'h5a17_c3e0_9b42_11d8_a6f0_0c4e_7d21_b398;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         q_valid = 1'b0;
  logic         q_kind = 1'b0;
  logic [127:0] q_id = '0;
  logic [31:0]  q_offset = '0;
  logic [31:0]  q_length = '0;
  logic         q_ready, ready, rsp_valid, dat_valid;
  logic [7:0]   rsp_code, dat_byte;
  logic [31:0]  rsp_value;

  always #2 clk = ~clk;

  cmd_effects_log dut_i (
    .clk(clk), .rst_n(rst_n), .log_id(LOGID),
    .q_valid(q_valid), .q_kind(q_kind), .q_id(q_id),
    .q_offset(q_offset), .q_length(q_length), .q_ready(q_ready),
    .ready(ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_value(rsp_value), .dat_valid(dat_valid), .dat_byte(dat_byte)
  );

  int checks = 0;
  int errors = 0;
  bit [7:0] mdl [BUF];
  int       mdl_n = 0;
  bit [7:0] got [BUF];
  int       got_n;
  bit [7:0] g_code;
  bit [31:0] g_val;
  bit       busy_leak;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench model of the support table, written as range tests
  function automatic void b_lookup(int s, int c, output bit hit, output bit [15:0] eff);
    hit = 1'b0; eff = 16'h0;
    if (s == 1 && c <= 3) begin
      hit = 1'b1;
      if (c == 1) eff = 16'h0010;
      if (c == 3) eff = 16'h0002;
    end else if (s == 2 && c == 0) hit = 1'b1;
    else if (s == 3 && c <= 1) begin
      hit = 1'b1;
      if (c == 1) eff = 16'h0008;
    end else if (s == 4 && c <= 1) hit = 1'b1;
    else if (s == 8'h40 && c == 0) hit = 1'b1;
    else if (s == 8'h41 && (c == 0 || c == 2 || c == 3)) begin
      hit = 1'b1;
      if (c == 3) eff = 16'h0006;
    end
  endfunction

  task automatic build_model();
    for (int i = 0; i < BUF; i++) mdl[i] = 8'h0;
    for (int s = 0; s < 256; s++)
      for (int c = 0; c < 256; c++) begin
        bit h; bit [15:0] e; bit [15:0] op;
        b_lookup(s, c, h, e);
        if (h) begin
          op = 16'(s * 256 + c);
          if (4*mdl_n + 3 < BUF) begin
            mdl[4*mdl_n]   = op[7:0];
            mdl[4*mdl_n+1] = op[15:8];
            mdl[4*mdl_n+2] = e[7:0];
            mdl[4*mdl_n+3] = e[15:8];
          end
          mdl_n++;
        end
      end
  endtask

  function automatic bit [7:0] exp_code(bit [31:0] off, bit [31:0] len, bit [127:0] id);
    bit [32:0] sum;
    sum = {1'b0, off} + {1'b0, len};
    if (sum > 33'(BUF)) return 8'h02;
    if (id != LOGID) return 8'h03;
    return 8'h00;
  endfunction

  task automatic run_query(bit kind, bit [127:0] id, bit [31:0] off, bit [31:0] len);
    int guard;
    @(negedge clk);
    q_valid = 1'b1; q_kind = kind; q_id = id; q_offset = off; q_length = len;
    while (!q_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    q_valid = 1'b0;
    got_n = 0; busy_leak = 1'b0; guard = 0;
    while (!rsp_valid && guard < 200) begin
      if (q_ready) busy_leak = 1'b1;
      if (dat_valid) begin
        if (got_n < BUF) got[got_n] = dat_byte;
        got_n++;
      end
      @(negedge clk);
      guard++;
    end
    g_code = rsp_code;
    g_val  = rsp_value;
  endtask

  task automatic judge_get(string req, bit [127:0] id, bit [31:0] off, bit [31:0] len);
    bit [7:0] ec;
    int bad;
    run_query(1'b1, id, off, len);
    ec = exp_code(off, len, id);
    check(req, "rsp_code", g_code, ec);
    check(req, "rsp_value", g_val, (ec == 8'h00) ? len : 0);
    check(req, "byte count", got_n, (ec == 8'h00) ? int'(len) : 0);
    check("R10", "q_ready while busy", busy_leak, 0);
    if (ec == 8'h00) begin
      bad = -1;
      for (int i = 0; i < got_n && i < BUF; i++)
        if (bad < 0 && got[i] != mdl[off + i]) bad = i;
      if (bad >= 0) check(req, "stream byte", got[bad], mdl[off + bad]);
      else          check(req, "stream bytes", 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lowcnt;
    bit stall_leak;
    int unused_seed;
    build_model();
    unused_seed = $urandom(32'h00C0_FFEE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "ready after reset", ready, 0);
    check("R10", "q_ready after reset", q_ready, 0);
    check("R8", "no response after reset", rsp_valid | dat_valid, 0);
    // R10 query held across the scan
    q_valid = 1'b1; q_kind = 1'b0; q_id = '0;
    lowcnt = 0; stall_leak = 1'b0;
    while (!ready) begin
      if (q_ready || rsp_valid) stall_leak = 1'b1;
      lowcnt++;
      @(negedge clk);
    end
    check("R10", "stall during scan", stall_leak, 0);
    check("R1", "scan covers all opcodes", (lowcnt >= 65535), 1);
    @(posedge clk);
    @(negedge clk);
    q_valid = 1'b0;
    check("R4", "held size query rsp", rsp_valid, 1);
    check("R4", "log size bytes", rsp_value, 4 * mdl_n);
    check("R4", "size code", rsp_code, 0);
    check("R2", "entry count", mdl_n, 13);
    check("R1", "ready stays high", ready, 1);

    // full log read
    judge_get("R2", LOGID, 0, 52);
    check("R9", "first entry opc lo", got[0], 8'h00);
    check("R9", "first entry opc hi", got[1], 8'h01);
    check("R3", "log change bit on 0x0101", got[6], 8'h10);
    check("R3", "policy bit on 0x0301", got[26], 8'h08);
    check("R9", "last entry opc lo", got[48], 8'h03);
    check("R9", "last entry opc hi", got[49], 8'h41);
    check("R3", "config+data bits on 0x4103", got[50], 8'h06);
    check("R9", "last entry eff hi", got[51], 8'h00);

    // corner cases
    judge_get("R8", LOGID, 60, 4);             // past log end, at buffer end
    judge_get("R5", LOGID, 61, 4);             // one byte past buffer
    judge_get("R6", LOGID, 32'hFFFF_FFF0, 32'h20); // wraps in 32 bits
    judge_get("R7", ~LOGID, 0, 8);             // wrong id
    judge_get("R7", ~LOGID, 60, 10);           // both bad: bounds wins
    judge_get("R11", LOGID, 10, 0);            // empty read
    judge_get("R8", LOGID, 3, 9);              // unaligned start
    run_query(1'b0, '0, 0, 0);
    check("R4", "size query again", g_val, 52);

    // random mix
    for (int k = 0; k < 40; k++) begin
      bit [31:0] o, l;
      bit [127:0] id;
      o  = $urandom_range(0, 70);
      l  = $urandom_range(0, 70);
      id = ($urandom_range(0, 3) == 0) ? {LOGID[127:1], ~LOGID[0]} : LOGID;
      judge_get("R8", id, o, l);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule